// File: doc/BRIEF.md
# Two-Stage Gated SD Clock Divider

This block derives two clock-enable streams from one parent clock for an SD card interface: a host-side enable and a card-side enable. A first counter divides the parent clock by a power of two chosen by a 3-bit code. The host enable pulses once per period of that first stage. A second counter divides the first stage's ticks by 2 or 4, and the card enable pulses once per period of that second stage. The overall card ratio is therefore the product of the two stages, from 2 up to 64.

Software programs one control register. The register holds a stop bit for each output, the source-stage code and the final-stage code. A new ratio is adopted only when a card period ends, so the ratio is never changed in the middle of a period. Each output stops and restarts at its own period boundary. A status output shows when both outputs are allowed to run.

Top module: `sdclk_div`

## Requirements
- R1: A synchronous reset sets the register to 0x300 (both stop bits set, both codes 0), holds both enables low and clears the running flag.
- R2: Register layout: bit 9 stops the host enable and bit 8 stops the card enable (1 means stopped). Bits 4:2 hold the source code and bits 1:0 hold the final code. Every other bit reads back as 0.
- R3: Source codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. The host enable pulses exactly once per source period.
- R4: Final code 0 divides by 2 and any nonzero final code divides by 4. The card period equals the source division times the final division, so two card pulses never fall on adjacent cycles.
- R5: Source codes 5, 6 and 7 divide exactly as code 4 does.
- R6: While an output's stop bit is 1, that output's enable stays low. The other output is not affected.
- R7: After a stop bit is cleared, that output produces its first pulse no sooner than one full period after the next boundary of its stage: between P+1 and 2P+1 cycles after the write, where P is the period of that output.
- R8: After a ratio change, the card interval already in progress completes at the old ratio. The interval after it uses the new ratio.
- R9: The running output is 1 exactly when both stop bits are 0. It follows the register with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 10 | Register write value |
| rd_data | output | 10 | Register read-back value |
| host_ce | output | 1 | Host-side clock enable, one pulse per source period |
| card_ce | output | 1 | Card clock enable, one pulse per total period |
| running | output | 1 | Both outputs allowed to run |

## Verification
The bench uses the default parameters: source exponent limit 4 and final divisions 2 and 4. These defaults make the full 2-to-64 card range reachable, including the largest ratio of 64. They also make the reserved source codes 5 to 7 land on the limit, so the clamp can be observed at the ports. A scoreboard measures the host and card pulse intervals for several code pairs. It includes a switch from a period of 4 to a period of 32 that is timed against a card pulse, which shows the boundary at which the new ratio takes over.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CTRL_W    = 10;
  localparam int HSTOP_BIT = 9;
  localparam int CSTOP_BIT = 8;
  localparam int SRC_LSB   = 2;
  localparam int SRC_W     = 3;
  localparam int FIN_LSB   = 0;
  localparam int FIN_W     = 2;
  localparam logic [CTRL_W-1:0] CTRL_MASK  = 10'h31F;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h300;

  typedef struct packed {
    logic             hstop;
    logic             cstop;
    logic [SRC_W-1:0] src;
    logic [FIN_W-1:0] fin;
  } sd_cfg_t;

  function automatic sd_cfg_t unpack_cfg(input logic [CTRL_W-1:0] r);
    sd_cfg_t c;
    c.hstop = r[HSTOP_BIT];
    c.cstop = r[CSTOP_BIT];
    c.src   = r[SRC_LSB +: SRC_W];
    c.fin   = r[FIN_LSB +: FIN_W];
    return c;
  endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= wr_data & CTRL_MASK;
  end
endmodule

// File: rtl/sdclk_stage.sv
module sdclk_stage #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [DIV_W-1:0] limit,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = adv && (cnt_q == (limit - DIV_W'(1)));
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic stop,
  output logic ce
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ce    <= 1'b0;
    end else begin
      ce <= boundary & run_q;
      if (boundary) run_q <= ~stop;
    end
  end
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int SRC_MAX_LOG2 = 4,
  parameter int FIN_LO       = 2,
  parameter int FIN_HI       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              host_ce,
  output logic              card_ce,
  output logic              running
);
  localparam int SRC_DIV_W = SRC_MAX_LOG2 + 1;
  localparam int FIN_DIV_W = $clog2(FIN_HI) + 1;
  localparam int N_OUT     = 2;

  logic [CTRL_W-1:0]    ctrl_q;
  sd_cfg_t              cfg;
  logic [SRC_W-1:0]     act_src;
  logic [FIN_W-1:0]     act_fin;
  logic [SRC_W-1:0]     src_exp;
  logic [SRC_DIV_W-1:0] src_div;
  logic [FIN_DIV_W-1:0] fin_div;
  logic [SRC_DIV_W-1:0] src_cnt;
  logic [FIN_DIV_W-1:0] fin_cnt;
  logic                 src_tick;
  logic                 fin_tick;
  logic [N_OUT-1:0]     bnd;
  logic [N_OUT-1:0]     stp;
  logic [N_OUT-1:0]     ce_vec;

  sdclk_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  assign cfg     = unpack_cfg(ctrl_q);
  assign rd_data = ctrl_q;

  // Active codes only change when a card period ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_src <= '0;
      act_fin <= '0;
    end else if (fin_tick) begin
      act_src <= cfg.src;
      act_fin <= cfg.fin;
    end
  end

  always_comb begin
    src_exp = (act_src > SRC_W'(SRC_MAX_LOG2)) ? SRC_W'(SRC_MAX_LOG2) : act_src;
    src_div = SRC_DIV_W'(1) << src_exp;
    fin_div = (act_fin == '0) ? FIN_DIV_W'(FIN_LO) : FIN_DIV_W'(FIN_HI);
  end

  sdclk_stage #(.DIV_W(SRC_DIV_W)) u_src (
    .clk(clk), .rst(rst), .adv(1'b1), .limit(src_div),
    .tick(src_tick), .cnt(src_cnt)
  );

  sdclk_stage #(.DIV_W(FIN_DIV_W)) u_fin (
    .clk(clk), .rst(rst), .adv(src_tick), .limit(fin_div),
    .tick(fin_tick), .cnt(fin_cnt)
  );

  assign bnd = {fin_tick, src_tick};
  assign stp = {cfg.cstop, cfg.hstop};

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
      sdclk_gate u_gate (
        .clk(clk), .rst(rst), .boundary(bnd[g]), .stop(stp[g]), .ce(ce_vec[g])
      );
    end
  endgenerate

  assign host_ce = ce_vec[0];
  assign card_ce = ce_vec[1];

  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= ~cfg.hstop & ~cfg.cstop;
  end
endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk
  import sdclk_pkg::*;
#(
  parameter int SRC_DIV_W = 5,
  parameter int FIN_DIV_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CTRL_W-1:0]    rd_data,
  input logic                 host_ce,
  input logic                 card_ce,
  input logic [SRC_DIV_W-1:0] src_cnt,
  input logic [SRC_DIV_W-1:0] src_div,
  input logic [FIN_DIV_W-1:0] fin_cnt,
  input logic [SRC_W-1:0]     act_src,
  input logic                 fin_tick
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rd_data == CTRL_RESET && !card_ce && !host_ce));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    src_cnt < src_div);

  p_card_gap_r4: assert property (@(posedge clk) disable iff (rst)
    card_ce |=> !card_ce);

  p_card_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    card_ce |-> (src_cnt == '0 && fin_cnt == '0));

  p_ratio_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_src) |-> $past(fin_tick));
endmodule

bind sdclk_div sdclk_div_chk #(.SRC_DIV_W(SRC_DIV_W), .FIN_DIV_W(FIN_DIV_W)) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .host_ce(host_ce), .card_ce(card_ce),
  .src_cnt(src_cnt), .src_div(src_div), .fin_cnt(fin_cnt), .act_src(act_src),
  .fin_tick(fin_tick)
);

// File: tb/sdclk_div_tb.sv
module sdclk_div_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic [9:0] rd_data;
  logic       host_ce, card_ce, running;

  int checks = 0, errors = 0, cyc = 0;
  int card_q[$], host_q[$];
  bit card_arm = 0, host_arm = 0;
  int last_card = 0, last_host = 0, card_cnt = 0, host_cnt = 0;
  string cur_tag = "";

  always #2.5 clk = ~clk;

  sdclk_div u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .host_ce(host_ce), .card_ce(card_ce), .running(running)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measures pulse intervals and pops expected periods.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (card_ce) begin
        card_cnt++;
        if (card_arm && card_q.size() > 0) begin
          int e;
          e = card_q.pop_front();
          check(cyc - last_card == e, {cur_tag, " card"}, cyc - last_card, e);
          if (card_q.size() == 0) card_arm = 0;
        end
        last_card = cyc;
      end
      if (host_ce) begin
        host_cnt++;
        if (host_arm && host_q.size() > 0) begin
          int e;
          e = host_q.pop_front();
          check(cyc - last_host == e, {cur_tag, " host"}, cyc - last_host, e);
          if (host_q.size() == 0) host_arm = 0;
        end
        last_host = cyc;
      end
    end
  end

  task automatic wr(input logic [9:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [9:0] cfgw(input bit hs, input bit cs, input int s, input int f);
    return {hs, cs, 3'b000, 3'(s), 2'(f)};
  endfunction

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && (card_q.size() > 0 || host_q.size() > 0); i++) @(negedge clk);
    check(card_q.size() == 0 && host_q.size() == 0, {tag, " drain"},
          card_q.size() + host_q.size(), 0);
    card_arm = 0; host_arm = 0; card_q.delete(); host_q.delete();
  endtask

  // Driver: program a ratio, let it settle, push expected periods.
  task automatic expect_ratio(input int s, input int f, input int cp, input int hp, input string tag);
    wr(cfgw(0, 0, s, f));
    repeat (300) @(negedge clk);
    cur_tag = tag;
    card_q.push_back(cp); card_q.push_back(cp);
    host_q.push_back(hp); host_q.push_back(hp);
    card_arm = 1; host_arm = 1;
    drain(tag);
  endtask

  initial begin
    int c0, h0, g;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rd_data == 10'h300, "R1 rd_data", rd_data, 10'h300);
    check(!card_ce && !host_ce, "R1 enables", {card_ce, host_ce}, 0);
    check(!running, "R1 running", running, 0);
    c0 = card_cnt; h0 = host_cnt;
    repeat (100) @(negedge clk);
    check(card_cnt == c0 && host_cnt == h0, "R6 stopped after reset",
          card_cnt - c0 + host_cnt - h0, 0);

    // R2: unused bits read back as zero
    wr(10'h3FF);
    check(rd_data == 10'h31F, "R2 readback mask", rd_data, 10'h31F);

    // R3/R4/R5 ratio scoreboard
    expect_ratio(0, 0, 2, 1, "R3 R4 src1 fin2");
    @(negedge clk);
    check(running == 1'b1, "R9 running set", running, 1);
    expect_ratio(1, 1, 8, 2, "R3 R4 src2 fin4");
    expect_ratio(4, 1, 64, 16, "R3 R4 src16 fin4");
    expect_ratio(2, 0, 8, 4, "R3 R4 src4 fin2");
    expect_ratio(6, 0, 32, 16, "R5 reserved src6");
    expect_ratio(7, 1, 64, 16, "R5 reserved src7");
    expect_ratio(3, 2, 32, 8, "R4 final code2");

    // R8: ratio change lands at card boundary (4 then 32)
    expect_ratio(1, 0, 4, 2, "R8 setup");
    @(negedge clk);
    while (!card_ce) @(negedge clk);
    @(negedge clk);
    cur_tag = "R8 ratio change";
    card_q.push_back(4); card_q.push_back(32); card_q.push_back(32);
    card_arm = 1;
    wr(cfgw(0, 0, 3, 1));
    drain("R8");

    // R6 + R9: card stopped, host running
    wr(cfgw(0, 1, 2, 1));
    repeat (2) @(negedge clk);
    check(running == 1'b0, "R9 running clear", running, 0);
    repeat (200) @(negedge clk);
    c0 = card_cnt; h0 = host_cnt;
    repeat (100) @(negedge clk);
    check(card_cnt == c0, "R6 card stopped", card_cnt - c0, 0);
    check(host_cnt - h0 == 25, "R6 host unaffected", host_cnt - h0, 25);

    // R7: restart of card, P = 16
    wr_en = 1'b1; wr_data = cfgw(0, 0, 2, 1);
    g = 0;
    @(negedge clk); wr_en = 1'b0; g = 1;
    while (!card_ce && g < 100) begin @(negedge clk); g++; end
    check(g > 16 && g <= 33, "R7 restart delay", g, 17);

    // R6: host stopped, card running
    wr(cfgw(1, 0, 1, 0));
    repeat (200) @(negedge clk);
    c0 = card_cnt; h0 = host_cnt;
    repeat (100) @(negedge clk);
    check(host_cnt == h0, "R6 host stopped", host_cnt - h0, 0);
    check(card_cnt - c0 == 25, "R6 card unaffected", card_cnt - c0, 25);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule